// File: doc/BRIEF.md
# I2C Host-Register Mailbox Slave

This block is an I2C slave that exposes a file of 256 eight-bit host registers to an external bus master. The same file is a two-way mailbox between that master and an internal processor. The master posts a command in two steps. It writes the command registers over I2C, then pulls a dedicated command pin low. The falling edge on that pin reaches the processor as a one-cycle interrupt pulse. The processor answers by filling request registers through its own write port and pulsing a raise input. That pulse pulls the active-low interrupt output toward the master low.

The master reads the request back over I2C. It then reads register 10, which acknowledges the request and releases the interrupt. A write transfer carries the device address, then a register number that loads an internal pointer, then data bytes. A read transfer returns bytes starting at the pointer. The pointer advances after every byte, so a whole request block can be read in one transfer.

The internal write port uses valid/ready. Ready falls only in a cycle in which an I2C write lands on the same register. In that case the I2C value is stored. The internal side must hold valid, address and data until it sees ready high at a clock edge. The internal read port is plain and combinational.

Top module: `hreg_mailbox`

## Requirements
- R1: The slave ACKs the address bytes 0x86 (write) and 0x87 (read), given as full 8-bit values with the direction in bit 0. Any other address byte is not ACKed, and the bytes that follow it until the next START are ignored.
- R2: In a write transfer, the first byte after the address loads the register pointer. Each later byte is written to the register at the pointer. The slave ACKs each of these bytes.
- R3: The pointer advances by one after every data byte written or read, and wraps from 255 to 0.
- R4: Each falling edge on `cmd_pin_n` produces exactly one single-cycle pulse on `cmd_irq_o`. A rising edge produces none.
- R5: A pulse on `req_raise_i` drives `irq_n_o` low in the next cycle. It then stays low through any further register traffic until the acknowledge of R7.
- R6: A read transfer returns the register at the pointer. It then returns the following registers for as long as the master ACKs. A NACK from the master ends the transfer.
- R7: When register 10 is loaded for transmission in a read transfer, `irq_n_o` returns high in the next cycle. This is its only release path.
- R8: An internal write is accepted at a clock edge when `cpu_wr_valid` and `cpu_wr_ready` are both high. Ready is low only when an I2C write hits the same register in that cycle, and then the I2C value is stored.
- R9: The slave changes its SDA drive only while SCL is low.
- R10: After reset, `irq_n_o` is high, SDA is released, `cmd_irq_o` is low and all registers read 0.
- R11: A START received in the middle of a byte restarts the address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed level of the I2C clock line |
| sda_i | input | 1 | Sensed level of the I2C data line |
| sda_low_o | output | 1 | High to pull the open-drain data line low |
| cmd_pin_n | input | 1 | Command-post pin from the master; a falling edge posts |
| cmd_irq_o | output | 1 | One-cycle command interrupt to the internal side |
| irq_n_o | output | 1 | Active-low request interrupt to the master |
| req_raise_i | input | 1 | Internal pulse that raises the request interrupt |
| cpu_wr_valid | input | 1 | Internal write request valid |
| cpu_wr_ready | output | 1 | Internal write accepted at this edge |
| cpu_wr_addr | input | 8 | Internal write register number |
| cpu_wr_data | input | 8 | Internal write data |
| cpu_rd_addr | input | 8 | Internal read register number |
| cpu_rd_data | output | 8 | Internal read data, combinational |

## Verification
The checks on the SDA drive assume that the master obeys the bus rules. It must change SDA only while SCL is low, except for START and STOP. It must never issue START or STOP while the slave is driving an ACK or a data bit. The interrupt checks assume that `req_raise_i` is a short pulse from the internal side and that the internal side holds a write until it is accepted. The bench master model moves SDA a quarter period after SCL falls. It issues START and STOP only on bit boundaries with SDA released by the slave, and it holds each internal write request until it sees ready.

// File: rtl/hreg_pkg.sv
package hreg_pkg;
  localparam int REG_AW = 8;
  localparam int REG_DW = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } eng_state_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_PTR,
    PH_DATA
  } rx_phase_t;
endpackage

// File: rtl/hreg_line_cond.sv
// Two-stage synchroniser and glitch filter for SCL/SDA, plus bus event decode.
module hreg_line_cond #(
  parameter int FILT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_f,
  output logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int CW = $clog2(FILT + 1);
  localparam int NL = 2;

  logic raw  [NL];
  logic filt [NL];
  logic prev [NL];

  assign raw[0] = scl_i;
  assign raw[1] = sda_i;

  for (genvar g = 0; g < NL; g++) begin : g_line
    logic s1, s2;
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1      <= 1'b1;
        s2      <= 1'b1;
        cnt     <= '0;
        filt[g] <= 1'b1;
        prev[g] <= 1'b1;
      end else begin
        s1      <= raw[g];
        s2      <= s1;
        prev[g] <= filt[g];
        if (s2 == filt[g]) begin
          cnt <= '0;
        end else if (cnt == CW'(FILT - 1)) begin
          filt[g] <= s2;
          cnt     <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign scl_f     = filt[0];
  assign sda_f     = filt[1];
  assign scl_rise  = filt[0] & ~prev[0];
  assign scl_fall  = ~filt[0] & prev[0];
  assign start_det = filt[0] & prev[0] & prev[1] & ~filt[1];
  assign stop_det  = filt[0] & prev[0] & ~prev[1] & filt[1];
endmodule

// File: rtl/hreg_i2c_engine.sv
// Byte-level slave: address match, pointer load, write and read phases.
module hreg_i2c_engine
  import hreg_pkg::*;
#(
  parameter int         AW       = REG_AW,
  parameter int         DW       = REG_DW,
  parameter logic [6:0] DEV_ADDR = 7'h43
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_f,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_ptr,
  output logic          tx_load,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          sda_low
);
  localparam logic [3:0] BITS = 4'(DW);

  eng_state_t    st;
  rx_phase_t     ph;
  logic [3:0]    bitcnt;
  logic [DW-1:0] shreg;
  logic [AW-1:0] ptr;
  logic          rd_mode;
  logic          mack;
  logic          byte_done;

  assign byte_done = scl_fall && (bitcnt == BITS);
  assign tx_load   = scl_fall && (((st == ST_ACK) && rd_mode) || ((st == ST_MACK) && mack));
  assign wr_en     = (st == ST_RX) && byte_done && (ph == PH_DATA);
  assign wr_addr   = ptr;
  assign wr_data   = shreg;
  assign rd_ptr    = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      ph      <= PH_ADDR;
      bitcnt  <= '0;
      shreg   <= '0;
      ptr     <= '0;
      rd_mode <= 1'b0;
      mack    <= 1'b0;
      sda_low <= 1'b0;
    end else if (start_det) begin
      st      <= ST_RX;
      ph      <= PH_ADDR;
      bitcnt  <= '0;
      sda_low <= 1'b0;
    end else if (stop_det) begin
      st      <= ST_IDLE;
      sda_low <= 1'b0;
    end else begin
      unique case (st)
        ST_RX: begin
          if (scl_rise) begin
            shreg  <= {shreg[DW-2:0], sda_f};
            bitcnt <= bitcnt + 1'b1;
          end else if (byte_done) begin
            bitcnt <= '0;
            unique case (ph)
              PH_ADDR: begin
                if (shreg[DW-1:1] == DEV_ADDR) begin
                  rd_mode <= shreg[0];
                  sda_low <= 1'b1;
                  st      <= ST_ACK;
                end else begin
                  st <= ST_IDLE;
                end
              end
              PH_PTR: begin
                ptr     <= shreg[AW-1:0];
                ph      <= PH_DATA;
                sda_low <= 1'b1;
                st      <= ST_ACK;
              end
              default: begin
                ptr     <= ptr + 1'b1;
                sda_low <= 1'b1;
                st      <= ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (rd_mode) begin
              shreg   <= rd_data;
              ptr     <= ptr + 1'b1;
              sda_low <= ~rd_data[DW-1];
              bitcnt  <= 4'd1;
              st      <= ST_TX;
            end else begin
              sda_low <= 1'b0;
              st      <= ST_RX;
              if (ph == PH_ADDR) ph <= PH_PTR;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt == BITS) begin
              sda_low <= 1'b0;
              st      <= ST_MACK;
            end else begin
              sda_low <= ~shreg[DW-2];
              shreg   <= {shreg[DW-2:0], 1'b0};
              bitcnt  <= bitcnt + 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack <= ~sda_f;
          end else if (scl_fall) begin
            if (mack) begin
              shreg   <= rd_data;
              ptr     <= ptr + 1'b1;
              sda_low <= ~rd_data[DW-1];
              bitcnt  <= 4'd1;
              st      <= ST_TX;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/hreg_file.sv
// Register file with an I2C port and an internal valid/ready write port.
module hreg_file #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_waddr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [AW-1:0] bus_raddr,
  output logic [DW-1:0] bus_rdata,
  input  logic          cpu_valid,
  output logic          cpu_ready,
  input  logic [AW-1:0] cpu_waddr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic [AW-1:0] cpu_raddr,
  output logic [DW-1:0] cpu_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  assign cpu_ready = !(bus_we && (bus_waddr == cpu_waddr));
  assign bus_rdata = mem[bus_raddr];
  assign cpu_rdata = mem[cpu_raddr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (cpu_valid && cpu_ready) mem[cpu_waddr] <= cpu_wdata;
      if (bus_we) mem[bus_waddr] <= bus_wdata;
    end
  end
endmodule

// File: rtl/hreg_irq_ctrl.sv
// Command-pin edge detection and the request interrupt flag.
module hreg_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_pin_n,
  input  logic req_raise,
  input  logic req_ack,
  output logic cmd_irq,
  output logic irq_n
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1    <= 1'b1;
      s2    <= 1'b1;
      s3    <= 1'b1;
      irq_n <= 1'b1;
    end else begin
      s1 <= cmd_pin_n;
      s2 <= s1;
      s3 <= s2;
      if (req_raise)    irq_n <= 1'b0;
      else if (req_ack) irq_n <= 1'b1;
    end
  end

  assign cmd_irq = s3 & ~s2;
endmodule

// File: rtl/hreg_mailbox.sv
module hreg_mailbox
  import hreg_pkg::*;
#(
  parameter int         FILT     = 3,
  parameter logic [6:0] DEV_ADDR = 7'h43,
  parameter int         ACK_REG  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_low_o,
  input  logic              cmd_pin_n,
  output logic              cmd_irq_o,
  output logic              irq_n_o,
  input  logic              req_raise_i,
  input  logic              cpu_wr_valid,
  output logic              cpu_wr_ready,
  input  logic [REG_AW-1:0] cpu_wr_addr,
  input  logic [REG_DW-1:0] cpu_wr_data,
  input  logic [REG_AW-1:0] cpu_rd_addr,
  output logic [REG_DW-1:0] cpu_rd_data
);
  logic              scl_f, sda_f, scl_rise, scl_fall, start_det, stop_det;
  logic              tx_load, i2c_we, ack10;
  logic [REG_AW-1:0] rd_ptr, i2c_waddr;
  logic [REG_DW-1:0] i2c_wdata, i2c_rdata;

  hreg_line_cond #(.FILT(FILT)) u_line (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_f(scl_f), .sda_f(sda_f), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  hreg_i2c_engine #(.AW(REG_AW), .DW(REG_DW), .DEV_ADDR(DEV_ADDR)) u_eng (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_f(sda_f), .start_det(start_det), .stop_det(stop_det),
    .rd_data(i2c_rdata), .rd_ptr(rd_ptr), .tx_load(tx_load),
    .wr_en(i2c_we), .wr_addr(i2c_waddr), .wr_data(i2c_wdata), .sda_low(sda_low_o)
  );

  hreg_file #(.AW(REG_AW), .DW(REG_DW)) u_file (
    .clk(clk), .rst_n(rst_n),
    .bus_we(i2c_we), .bus_waddr(i2c_waddr), .bus_wdata(i2c_wdata),
    .bus_raddr(rd_ptr), .bus_rdata(i2c_rdata),
    .cpu_valid(cpu_wr_valid), .cpu_ready(cpu_wr_ready),
    .cpu_waddr(cpu_wr_addr), .cpu_wdata(cpu_wr_data),
    .cpu_raddr(cpu_rd_addr), .cpu_rdata(cpu_rd_data)
  );

  assign ack10 = tx_load && (rd_ptr == REG_AW'(ACK_REG));

  hreg_irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n), .cmd_pin_n(cmd_pin_n), .req_raise(req_raise_i),
    .req_ack(ack10), .cmd_irq(cmd_irq_o), .irq_n(irq_n_o)
  );
endmodule

// File: rtl/hreg_mailbox_chk.sv
module hreg_mailbox_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_irq_o,
  input logic irq_n_o,
  input logic req_raise_i,
  input logic ack10,
  input logic scl_f,
  input logic sda_low_o,
  input logic cpu_wr_valid,
  input logic cpu_wr_ready,
  input logic i2c_we
);
  assert_cmd_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_irq_o |=> !cmd_irq_o);

  assert_irq_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_raise_i |=> !irq_n_o);

  assert_irq_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n_o && !ack10) |=> !irq_n_o);

  assert_irq_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n_o) |-> $past(ack10));

  assert_backpressure_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_valid && !cpu_wr_ready) |-> i2c_we);

  assert_sda_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f && $past(scl_f)) |-> $stable(sda_low_o));
endmodule

bind hreg_mailbox hreg_mailbox_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_irq_o(cmd_irq_o), .irq_n_o(irq_n_o),
  .req_raise_i(req_raise_i), .ack10(ack10), .scl_f(scl_f),
  .sda_low_o(sda_low_o), .cpu_wr_valid(cpu_wr_valid),
  .cpu_wr_ready(cpu_wr_ready), .i2c_we(i2c_we)
);

// File: tb/hreg_mailbox_test.sv
module hreg_mailbox_test;
  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_line;
  logic       sda_low_o;
  logic       cmd_pin_n = 1'b1;
  logic       cmd_irq_o;
  logic       irq_n_o;
  logic       req_raise_i = 1'b0;
  logic       cpu_wr_valid = 1'b0;
  logic       cpu_wr_ready;
  logic [7:0] cpu_wr_addr = '0;
  logic [7:0] cpu_wr_data = '0;
  logic [7:0] cpu_rd_addr = '0;
  logic [7:0] cpu_rd_data;

  int n_tests = 0;
  int n_fail  = 0;
  int pulse_cnt = 0;
  int r9_viol = 0;
  logic prev_scl = 1'b1;
  logic prev_low = 1'b0;
  logic [7:0] model [256];
  logic [7:0] wbuf [64];
  logic [7:0] rbuf [64];

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_low_o;

  hreg_mailbox uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_low_o(sda_low_o),
    .cmd_pin_n(cmd_pin_n), .cmd_irq_o(cmd_irq_o), .irq_n_o(irq_n_o),
    .req_raise_i(req_raise_i), .cpu_wr_valid(cpu_wr_valid), .cpu_wr_ready(cpu_wr_ready),
    .cpu_wr_addr(cpu_wr_addr), .cpu_wr_data(cpu_wr_data),
    .cpu_rd_addr(cpu_rd_addr), .cpu_rd_data(cpu_rd_data)
  );

  always @(negedge clk) begin
    if (cmd_irq_o) pulse_cnt++;
    if (rst_n && scl_m && prev_scl && (sda_low_o != prev_low)) r9_viol++;
    prev_scl = scl_m;
    prev_low = sda_low_o;
  end

  function automatic bit exp_ack(input logic [7:0] a);
    return a[7:1] == 7'h43;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; hold(Q);
    scl_m = 1'b1; hold(Q);
    sda_m = 1'b0; hold(Q);
    scl_m = 1'b0; hold(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; hold(Q);
    scl_m = 1'b1; hold(Q);
    sda_m = 1'b1; hold(2 * Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; hold(Q);
    scl_m = 1'b1; hold(2 * Q);
    scl_m = 1'b0; hold(Q);
  endtask

  task automatic i2c_wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; hold(Q);
    scl_m = 1'b1; hold(Q);
    ack = ~sda_line;
    hold(Q);
    scl_m = 1'b0; hold(Q);
  endtask

  task automatic i2c_rbyte(input logic nack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; hold(Q);
      scl_m = 1'b1; hold(Q);
      d[i] = sda_line;
      hold(Q);
      scl_m = 1'b0; hold(Q);
    end
    send_bit(nack);
  endtask

  task automatic write_block(input logic [7:0] a, input int len, input string req);
    logic ack;
    i2c_start();
    i2c_wbyte(8'h86, ack); check(req, ack, 1);
    i2c_wbyte(a, ack);     check(req, ack, 1);
    for (int i = 0; i < len; i++) begin
      i2c_wbyte(wbuf[i], ack);
      check(req, ack, 1);
      model[8'(a + i)] = wbuf[i];
    end
    i2c_stop();
  endtask

  task automatic read_block(input logic [7:0] a, input int len, input string req);
    logic ack;
    logic [7:0] d;
    i2c_start();
    i2c_wbyte(8'h86, ack); check(req, ack, 1);
    i2c_wbyte(a, ack);     check(req, ack, 1);
    i2c_start();
    i2c_wbyte(8'h87, ack); check(req, ack, 1);
    for (int i = 0; i < len; i++) begin
      i2c_rbyte(i == len - 1, d);
      rbuf[i] = d;
    end
    i2c_stop();
  endtask

  task automatic cpu_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_wr_valid = 1'b1; cpu_wr_addr = a; cpu_wr_data = d;
    #1;
    check("R8 idle accept", cpu_wr_ready, 1);
    @(negedge clk);
    cpu_wr_valid = 1'b0;
    model[a] = d;
  endtask

  task automatic cpu_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_rd_addr = a;
    #1;
    d = cpu_rd_data;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic ack;
    logic [7:0] d;
    int seed;
    bit seen;
    seed = $urandom(32'h5EED);
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    hold(5);
    rst_n = 1'b1;
    hold(5);

    // R10 reset state
    check("R10 irq_n", irq_n_o, 1);
    check("R10 sda", sda_low_o, 0);
    check("R10 cmd_irq", cmd_irq_o, 0);
    cpu_read(8'd64, d); check("R10 reg64", d, 0);

    // R1 foreign address: NACK, following bytes ignored
    i2c_start();
    i2c_wbyte(8'h90, ack); check("R1 foreign nack", ack, exp_ack(8'h90));
    i2c_wbyte(8'd5, ack);
    i2c_wbyte(8'hEE, ack);
    i2c_stop();
    cpu_read(8'd5, d); check("R1 ignored write", d, 0);

    // R2/R3 command block 64..69
    for (int i = 0; i < 6; i++) wbuf[i] = 8'(8'h70 + i * 3);
    write_block(8'd64, 6, "R2 cmd write ack");
    for (int i = 0; i < 6; i++) begin
      cpu_read(8'(64 + i), d); check("R3 cmd block", d, model[64 + i]);
    end

    // R4 command pin edges
    pulse_cnt = 0;
    cmd_pin_n = 1'b0; hold(20);
    check("R4 falling one pulse", pulse_cnt, 1);
    cmd_pin_n = 1'b1; hold(20);
    check("R4 rising no pulse", pulse_cnt, 1);

    // R5 request raise, block 70..78
    for (int i = 70; i <= 78; i++) cpu_write(8'(i), 8'($urandom));
    @(negedge clk); req_raise_i = 1'b1;
    @(negedge clk); req_raise_i = 1'b0;
    check("R5 irq low", irq_n_o, 0);
    cpu_write(8'd71, 8'hA5);
    read_block(8'd70, 9, "R6 read ack");
    for (int i = 0; i < 9; i++) check("R6 req block", rbuf[i], model[70 + i]);
    check("R5 irq held", irq_n_o, 0);

    // R6 long block 134..169
    for (int i = 134; i <= 169; i++) cpu_write(8'(i), 8'($urandom));
    read_block(8'd134, 36, "R6 read ack");
    for (int i = 0; i < 36; i++) check("R6 long block", rbuf[i], model[134 + i]);
    check("R5 irq still held", irq_n_o, 0);

    // R7 acknowledge by reading register 10
    read_block(8'd10, 1, "R7 read ack");
    check("R7 irq released", irq_n_o, 1);

    // R3 wrap
    wbuf[0] = 8'h3C; wbuf[1] = 8'hC3;
    write_block(8'd255, 2, "R3 wrap ack");
    cpu_read(8'd255, d); check("R3 wrap 255", d, 8'h3C);
    cpu_read(8'd0, d);   check("R3 wrap 0", d, 8'hC3);

    // R11 START inside a byte
    i2c_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
    i2c_start();
    i2c_wbyte(8'h86, ack); check("R11 restart ack", ack, 1);
    i2c_wbyte(8'd31, ack);
    i2c_wbyte(8'h77, ack);
    i2c_stop();
    model[31] = 8'h77;
    cpu_read(8'd31, d); check("R11 restart write", d, 8'h77);

    // R8 collision
    @(negedge clk);
    cpu_wr_valid = 1'b1; cpu_wr_addr = 8'd200; cpu_wr_data = 8'h11;
    seen = 1'b0;
    fork
      begin
        wbuf[0] = 8'h5A;
        write_block(8'd200, 1, "R8 bus write ack");
      end
      begin
        for (int k = 0; k < 4000 && !seen; k++) begin
          @(negedge clk);
          #1;
          if (!cpu_wr_ready) seen = 1'b1;
        end
        @(negedge clk);
        cpu_wr_valid = 1'b0;
      end
    join
    check("R8 ready dropped", seen, 1);
    cpu_read(8'd200, d); check("R8 bus wins", d, 8'h5A);
    model[200] = 8'h5A;

    // Random blocks
    for (int r = 0; r < 5; r++) begin
      logic [7:0] a;
      int len;
      a = 8'($urandom_range(0, 255));
      len = $urandom_range(1, 5);
      for (int i = 0; i < len; i++) wbuf[i] = 8'($urandom);
      write_block(a, len, "R2 random ack");
      for (int i = 0; i < len; i++) begin
        cpu_read(8'(a + i), d); check("R2 random write", d, model[8'(a + i)]);
      end
      read_block(a, len, "R6 random ack");
      for (int i = 0; i < len; i++) check("R6 random read", rbuf[i], model[8'(a + i)]);
    end

    check("R9 sda while scl high", r9_viol, 0);
    hold(10);
    finish_run();
  end
endmodule